// File: doc/BRIEF.md
# Cascaded-Sync PWM Stage with Carrier Gating

This block is one stage of a chain of pulse-width modulators. Software loads a period, a rising-edge count and a falling-edge count through a small register load port. The stage waits in an idle state until a start pulse arrives on `sync_in`. It then runs a counter over each period and drives `pwm_out` high while the count lies inside the programmed window. The output can be ANDed with an external carrier, so the waveform comes out modulated by that carrier.

The same start pulse is passed on through `sync_out` after a programmable delay, and `sync_out` feeds the `sync_in` of the next stage. A chain of stages can therefore start in step (delay zero) or staggered in phase.

New period and edge values go into shadow registers. They reach the active registers when the stage starts, and at a period boundary only while `te_in` is high. `te_out` passes that enable on to the next stage one cycle later. A `trap_in` input forces the output to a programmed safe level at once. The stage stays trapped until software clears it.

The controller has three states. IDLE moves to RUN on a start pulse and to TRAP on a trap. RUN moves to TRAP on a trap. TRAP moves back to IDLE on a clear write made while the trap input is low.

Top module: `cspwm_stage`

## Requirements
- R1: After reset, and in IDLE with `trap_in` low, `pwm_out` is low whatever is programmed. `sync_out` and `te_out` are low after reset.
- R2: A `sync_in` pulse in IDLE, with `trap_in` low, moves the stage to RUN at the next edge. It also copies all shadow values to the active set. The count is 0 in the first RUN cycle, and `pwm_out` stays low during the cycle that carries the pulse.
- R3: In RUN the count steps 0,1,…,period and then wraps to 0, so one period lasts period+1 cycles. Without the carrier, `pwm_out` is high exactly when rise ≤ count < fall.
- R4: When control bit 1 (carrier enable) is set, the RUN output is the R3 window ANDed with `carrier_in` in the same cycle.
- R5: With a delay of 0, `sync_out` equals `sync_in` in the same cycle. With a delay d > 0, a `sync_in` pulse in cycle 0 gives a one-cycle `sync_out` pulse in cycle d, and `sync_out` stays low in the cycles before it.
- R6: Writes with select 0 (period), 1 (rise) and 2 (fall) go to shadow registers. In RUN the shadows reach the active set only at the edge that ends the last count of a period with `te_in` high. With `te_in` low the running waveform keeps its old values.
- R7: `te_out` equals `te_in` delayed by one clock.
- R8: While `trap_in` is high, `pwm_out` equals control bit 0 (safe level) in the same cycle. From IDLE or RUN the stage enters TRAP at the next edge.
- R9: In TRAP `pwm_out` holds the safe level and `sync_in` is ignored. The stage returns to IDLE only on a write with select 4 that has control bit 2 (clear) set while `trap_in` is low. Select 3 loads the sync delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register load strobe |
| cfg_sel | input | 3 | Register select: 0 period, 1 rise, 2 fall, 3 delay, 4 control |
| cfg_data | input | CW | Load data; control bits: 0 safe level, 1 carrier enable, 2 trap clear |
| sync_in | input | 1 | Start pulse from the previous stage |
| sync_out | output | 1 | Delayed start pulse to the next stage |
| te_in | input | 1 | Transfer enable for shadow-to-active copies |
| te_out | output | 1 | Transfer enable passed to the next stage |
| carrier_in | input | 1 | External carrier used for gating |
| trap_in | input | 1 | Fault input forcing the safe level |
| pwm_out | output | 1 | Modulated PWM output |

## Verification
The assertions assume every input is synchronous to `clk` and settles between edges. They also assume `sync_in` is a single-cycle pulse, so the delay check and the start check each see one well-defined start. The stimulus changes inputs only a few nanoseconds after a rising edge and gives every start as a one-cycle pulse. Trap and clear inputs are applied only in the state sequences that the requirements describe. Programmed windows include the empty case (rise equal to fall) and the case where the window is wider than the period, so the edge comparisons make no assumption about how rise and fall are ordered.

// File: rtl/cspwm_pkg.sv
package cspwm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TRAP = 2'd2
    } pwm_state_e;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_PERIOD = 3'd0;
    localparam logic [SEL_W-1:0] SEL_RISE   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_FALL   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_DELAY  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd4;

    localparam int CTRL_SAFE  = 0;
    localparam int CTRL_CAREN = 1;
    localparam int CTRL_CLEAR = 2;

    localparam int N_SHADOW = 3;

endpackage

// File: rtl/cspwm_regs.sv
module cspwm_regs
    import cspwm_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CW-1:0]    cfg_data,
    input  logic             load_act,
    output logic [CW-1:0]    act_period,
    output logic [CW-1:0]    act_rise,
    output logic [CW-1:0]    act_fall,
    output logic [DW-1:0]    dly,
    output logic             safe_lvl,
    output logic             car_en,
    output logic             trap_clr
);

    logic [CW-1:0] shd [N_SHADOW];
    logic [CW-1:0] act [N_SHADOW];

    // Shadow and active copies of period, rise and fall (selects 0..2)
    for (genvar i = 0; i < N_SHADOW; i++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shd[i] <= '0;
            end else if (cfg_we && cfg_sel == SEL_W'(i)) begin
                shd[i] <= cfg_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act[i] <= '0;
            end else if (load_act) begin
                act[i] <= shd[i];
            end
        end
    end

    assign act_period = act[0];
    assign act_rise   = act[1];
    assign act_fall   = act[2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly      <= '0;
            safe_lvl <= 1'b0;
            car_en   <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_DELAY) begin
                dly <= cfg_data[DW-1:0];
            end
            if (cfg_sel == SEL_CTRL) begin
                safe_lvl <= cfg_data[CTRL_SAFE];
                car_en   <= cfg_data[CTRL_CAREN];
            end
        end
    end

    // Clear is a one-shot request, not a stored bit
    assign trap_clr = cfg_we && (cfg_sel == SEL_CTRL) && cfg_data[CTRL_CLEAR];

endmodule

// File: rtl/cspwm_delay.sv
module cspwm_delay #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_in,
    input  logic [DW-1:0] dly,
    output logic          sync_out
);

    logic          busy;
    logic [DW-1:0] left;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            left <= '0;
        end else if (sync_in && dly != '0) begin
            busy <= 1'b1;
            left <= dly - 1'b1;
        end else if (busy) begin
            if (left == '0) begin
                busy <= 1'b0;
            end else begin
                left <= left - 1'b1;
            end
        end
    end

    // Zero delay passes the pulse straight through
    assign sync_out = (dly == '0) ? sync_in : (busy && left == '0);

endmodule

// File: rtl/cspwm_counter.sv
module cspwm_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic          last
);

    assign last = run && (cnt == period);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cspwm_stage.sv
module cspwm_stage
    import cspwm_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CW-1:0]    cfg_data,
    input  logic             sync_in,
    output logic             sync_out,
    input  logic             te_in,
    output logic             te_out,
    input  logic             carrier_in,
    input  logic             trap_in,
    output logic             pwm_out
);

    pwm_state_e    state, state_nx;
    logic [CW-1:0] act_period, act_rise, act_fall;
    logic [DW-1:0] dly;
    logic          safe_lvl, car_en, trap_clr;
    logic [CW-1:0] cnt;
    logic          last;
    logic          start_go;
    logic          load_act;
    logic          in_win;
    logic          gated;

    assign start_go = (state == ST_IDLE) && sync_in && !trap_in;
    assign load_act = start_go || (last && te_in);

    cspwm_regs #(.CW(CW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_data   (cfg_data),
        .load_act   (load_act),
        .act_period (act_period),
        .act_rise   (act_rise),
        .act_fall   (act_fall),
        .dly        (dly),
        .safe_lvl   (safe_lvl),
        .car_en     (car_en),
        .trap_clr   (trap_clr)
    );

    cspwm_delay #(.DW(DW)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .dly      (dly),
        .sync_out (sync_out)
    );

    cspwm_counter #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_RUN),
        .period (act_period),
        .cnt    (cnt),
        .last   (last)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (trap_in)      state_nx = ST_TRAP;
                else if (sync_in) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (trap_in)      state_nx = ST_TRAP;
            end
            ST_TRAP: begin
                if (trap_clr && !trap_in) state_nx = ST_IDLE;
            end
            default: state_nx = ST_TRAP;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) te_out <= 1'b0;
        else        te_out <= te_in;
    end

    assign in_win = (cnt >= act_rise) && (cnt < act_fall);
    assign gated  = in_win && (car_en ? carrier_in : 1'b1);

    // Output logic
    always_comb begin
        unique case (state)
            ST_IDLE: pwm_out = trap_in ? safe_lvl : 1'b0;
            ST_RUN:  pwm_out = trap_in ? safe_lvl : gated;
            ST_TRAP: pwm_out = safe_lvl;
            default: pwm_out = safe_lvl;
        endcase
    end

endmodule

// File: rtl/cspwm_stage_chk.sv
module cspwm_stage_chk
    import cspwm_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input pwm_state_e    state,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] act_period,
    input logic [DW-1:0] dly,
    input logic          safe_lvl,
    input logic          trap_clr,
    input logic          sync_in,
    input logic          sync_out,
    input logic          te_in,
    input logic          te_out,
    input logic          trap_in,
    input logic          pwm_out
);

    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !trap_in) |-> !pwm_out);

    a_r2_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && sync_in && !trap_in) |=> (state == ST_RUN && cnt == '0));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (cnt <= act_period));

    a_r5_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (dly == '0) |-> (sync_out == sync_in));

    a_r6_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cnt == act_period && !te_in) |=> $stable(act_period));

    a_r7_te_high: assert property (@(posedge clk) disable iff (!rst_n)
        te_in |=> te_out);

    a_r7_te_low: assert property (@(posedge clk) disable iff (!rst_n)
        !te_in |=> !te_out);

    a_r8_safe_level: assert property (@(posedge clk) disable iff (!rst_n)
        trap_in |-> (pwm_out == safe_lvl));

    a_r8_enter_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap_in |=> (state == ST_TRAP));

    a_r9_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRAP && !(trap_clr && !trap_in)) |=> (state == ST_TRAP));

endmodule

bind cspwm_stage cspwm_stage_chk #(.CW(CW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .cnt        (cnt),
    .act_period (act_period),
    .dly        (dly),
    .safe_lvl   (safe_lvl),
    .trap_clr   (trap_clr),
    .sync_in    (sync_in),
    .sync_out   (sync_out),
    .te_in      (te_in),
    .te_out     (te_out),
    .trap_in    (trap_in),
    .pwm_out    (pwm_out)
);

// File: tb/cspwm_stage_test.sv
module cspwm_stage_test;
    localparam int CW = 8;
    localparam int DW = 8;

    // Fields: {carrier enable, period, rise, fall}
    localparam logic [24:0] VEC [4] = '{
        {1'b0, 8'd7, 8'd2, 8'd5},
        {1'b0, 8'd4, 8'd0, 8'd5},
        {1'b0, 8'd9, 8'd3, 8'd3},
        {1'b1, 8'd5, 8'd1, 8'd4}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [CW-1:0] cfg_data = '0;
    logic          sync_in = 1'b0;
    logic          te_in = 1'b0;
    logic          carrier_in = 1'b0;
    logic          trap_in = 1'b0;
    logic          sync_out, te_out, pwm_out;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cspwm_stage #(.CW(CW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .sync_in(sync_in), .sync_out(sync_out),
        .te_in(te_in), .te_out(te_out), .carrier_in(carrier_in),
        .trap_in(trap_in), .pwm_out(pwm_out)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [CW-1:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sync_in = 1'b0; te_in = 1'b0; trap_in = 1'b0;
        carrier_in = 1'b0; cfg_we = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic start();
        sync_in = 1'b1;
        step();
        sync_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state and idle output
        do_reset();
        #1;
        chk("R1 reset pwm_out", pwm_out, 1'b0);
        chk("R1 reset sync_out", sync_out, 1'b0);
        chk("R1 reset te_out", te_out, 1'b0);
        wr(3'd0, 8'd4); wr(3'd1, 8'd0); wr(3'd2, 8'd5);
        repeat (3) begin
            #1; chk("R1 idle without sync", pwm_out, 1'b0);
            step();
        end

        // Table walk: R3 windows, R4 carrier gating
        for (int v = 0; v < 4; v++) begin
            logic       cen;
            logic [7:0] p, r, f;
            {cen, p, r, f} = VEC[v];
            do_reset();
            wr(3'd0, p); wr(3'd1, r); wr(3'd2, f);
            wr(3'd4, {6'b0, cen, 1'b0});
            start();
            for (int j = 0; j < 2 * (p + 1); j++) begin
                int   c;
                logic e;
                c = j % (p + 1);
                carrier_in = j[0];
                #1;
                e = (c >= r && c < f) && (!cen || carrier_in);
                chk(cen ? "R4 carrier gating" : "R3 window", pwm_out, e);
                step();
            end
        end

        // R5: zero delay and delayed pulse
        do_reset();
        wr(3'd3, 8'd0);
        sync_in = 1'b1; #1;
        chk("R5 zero delay pass", sync_out, 1'b1);
        step(); sync_in = 1'b0; #1;
        chk("R5 zero delay end", sync_out, 1'b0);
        do_reset();
        wr(3'd3, 8'd3);
        sync_in = 1'b1; #1;
        chk("R5 no pulse at cycle 0", sync_out, 1'b0);
        step(); sync_in = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            #1; chk("R5 delayed pulse", sync_out, k == 3);
            step();
        end

        // R6 shadow hold and transfer, R7 enable echo
        do_reset();
        wr(3'd0, 8'd3); wr(3'd1, 8'd0); wr(3'd2, 8'd2);
        start();              // cycle 1, count 0
        wr(3'd0, 8'd5);       // cycle 2, count 1
        for (int j = 2; j <= 9; j++) begin
            #1; chk("R6 shadow held with te_in low", pwm_out, ((j - 1) % 4) < 2);
            step();
        end
        te_in = 1'b1;
        for (int j = 10; j <= 24; j++) begin
            int c;
            c = (j <= 12) ? ((j - 1) % 4) : ((j - 13) % 6);
            #1;
            chk("R6 transfer at boundary", pwm_out, c < 2);
            if (j == 10) chk("R7 te_out lags", te_out, 1'b0);
            if (j == 11) chk("R7 te_out follows", te_out, 1'b1);
            step();
        end
        te_in = 1'b0; #1;
        chk("R7 te_out still high", te_out, 1'b1);
        step(); #1;
        chk("R7 te_out drops", te_out, 1'b0);

        // R8, R9 trap behaviour and R2 restart
        do_reset();
        wr(3'd0, 8'd7); wr(3'd1, 8'd0); wr(3'd2, 8'd8); wr(3'd4, 8'd0);
        start(); #1;
        chk("R2 running after sync", pwm_out, 1'b1);
        trap_in = 1'b1; #1;
        chk("R8 same-cycle safe level", pwm_out, 1'b0);
        step(); trap_in = 1'b0; #1;
        chk("R9 trap held", pwm_out, 1'b0);
        sync_in = 1'b1; step(); sync_in = 1'b0;
        repeat (2) begin
            #1; chk("R9 sync ignored in trap", pwm_out, 1'b0);
            step();
        end
        wr(3'd4, 8'h04); #1;
        chk("R9 idle after clear", pwm_out, 1'b0);
        sync_in = 1'b1; #1;
        chk("R2 low in sync cycle", pwm_out, 1'b0);
        step(); sync_in = 1'b0; #1;
        chk("R2 starts at count 0", pwm_out, 1'b1);
        trap_in = 1'b1;
        step();
        wr(3'd4, 8'h04);      // clear while trap_in high: ignored
        trap_in = 1'b0;
        wr(3'd4, 8'h01);      // safe level 1, no clear
        #1;
        chk("R9 clear ignored while trap_in high", pwm_out, 1'b1);
        chk("R8 programmed safe level", pwm_out, 1'b1);
        wr(3'd4, 8'h05); #1;
        chk("R9 clear returns to idle", pwm_out, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule